// File: doc/BRIEF.md
# Radio Register SPI Access Master

This block turns a single register request from a host into one SPI transaction towards a radio transceiver. The transceiver holds two register spaces: a short space with 6-bit addresses and a long space with 10-bit addresses. Each space frames its command header differently. A short access uses a one-byte header. A long access uses a two-byte header. The host presents the space, the direction, the address and the write data on a valid strobe while `ready` is high. For a read, the byte returned by the transceiver appears on `rdata` together with a one-cycle `done` pulse.

The serial side runs in SPI mode 0, MSB first. SCLK idles low and is derived from the system clock by a fixed divider: each SCLK half period is `HALF_DIV` system cycles. The host's interrupt-enable level passes through the block, and it is forced off for as long as a transaction is in flight, so that an interrupt handler cannot start a second access that would interleave with the current one.

Top module: `radio_reg_spi_master`

## Requirements
- R1: A short-space write (req_long=0, req_write=1) sends exactly two bytes. The first is {1'b0, addr[5:0], 1'b1}, bit 7 first. The second is the write data.
- R2: A short-space read (req_long=0, req_write=0) sends the header {1'b0, addr[5:0], 1'b0} and then clocks 8 more bits, with MOSI held at 0. The 8 MISO bits of that second byte are presented on rdata, first bit as bit 7, in the cycle `done` is high.
- R3: The first byte of a long-space access is {1'b1, addr[9:3]}.
- R4: The second byte of a long-space access is {addr[2:0], write, 4'b0000}: the address low bits sit in bits 7:5, the direction in bit 4 (1 = write), and bits 3:0 are zero.
- R5: A long-space write sends three bytes: the two header bytes, then the data. A long-space read sends the two header bytes, then clocks in one data byte on MISO and returns it on rdata, while MOSI is held at 0.
- R6: SCLK is low whenever spi_cs_n is high. spi_cs_n falls before the first rising SCLK edge and rises only after the last falling edge. MOSI changes only while SCLK is low. MISO is sampled on the rising SCLK edge.
- R7: Between two transactions spi_cs_n stays high for at least 2*HALF_DIV system cycles, which is one SCLK period. `done` is a single-cycle pulse. `ready` is low from the cycle after a request is accepted until `done`. A req_valid seen while ready is low is ignored.
- R8: irq_en_out is forced to 0 from the acceptance of a request until `done`. In every other cycle it equals irq_en_in.
- R9: After reset, spi_cs_n=1, spi_sclk=0, ready=1 and done=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while ready is high |
| req_long | input | 1 | 1 = long (10-bit) space, 0 = short (6-bit) space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Register address (short space uses bits 5:0) |
| req_wdata | input | 8 | Write data |
| ready | output | 1 | Idle, a request may be presented |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data, valid with done |
| irq_en_in | input | 1 | Host interrupt-enable level |
| irq_en_out | output | 1 | Interrupt enable, masked during a transaction |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the transceiver |
| spi_miso | input | 1 | Serial data from the transceiver |

## Verification
A slave model with both register spaces, each filled with address-dependent values, decodes every frame it receives. The four space and direction combinations are applied at the address extremes (all zeros, all ones) and at mixed bit patterns. The extremes show whether the address bits are shifted or misplaced in the header. The mixed patterns separate the direction bit from address bit 0 in the short header, and bit 4 from the address low bits in the long header. Reads that follow writes to the same register show whether the correct captured byte is returned. Back-to-back requests, a request strobed while busy, and a run with the interrupt enable low exercise the chip-select gap, the rule that requests are ignored while busy, and the interrupt masking.

// File: rtl/rrm_pkg.sv
package rrm_pkg;

    localparam int FRAME_W   = 24;
    localparam int NBITS_W   = 5;
    localparam int SADDR_W   = 6;
    localparam int LADDR_W   = 10;
    localparam int DATA_W    = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2
    } rrm_state_e;

    typedef struct packed {
        logic               long_space;
        logic               write;
        logic [LADDR_W-1:0] addr;
        logic [DATA_W-1:0]  wdata;
    } rrm_req_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;   // left aligned, bit 23 leaves first
        logic [NBITS_W-1:0] nbits;
    } rrm_frame_t;

    // Header framing differs per space; read data slots carry zeros.
    function automatic rrm_frame_t build_frame(input rrm_req_t r);
        rrm_frame_t        f;
        logic [DATA_W-1:0] payload;
        payload = r.write ? r.wdata : '0;
        if (r.long_space) begin
            f.bits  = {1'b1, r.addr[9:3], r.addr[2:0], r.write, 4'b0000, payload};
            f.nbits = NBITS_W'(24);
        end else begin
            f.bits  = {1'b0, r.addr[SADDR_W-1:0], r.write, payload, 8'h00};
            f.nbits = NBITS_W'(16);
        end
        return f;
    endfunction

endpackage

// File: rtl/rrm_tick_gen.sv
module rrm_tick_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CNT_W-1:0] cnt;

    assign tick = en && (cnt == CNT_W'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rrm_shifter.sv
module rrm_shifter
    import rrm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  rrm_frame_t        frame,
    input  logic              tick,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              last,
    output logic [DATA_W-1:0] rx_byte
);
    logic [FRAME_W-1:0] sh;
    logic [NBITS_W-1:0] nbits;
    logic [NBITS_W-1:0] cnt;
    logic               active;

    assign mosi = sh[FRAME_W-1];
    assign last = active && tick && sclk && (cnt == nbits - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            nbits   <= '0;
            cnt     <= '0;
            sclk    <= 1'b0;
            active  <= 1'b0;
            rx_byte <= '0;
        end else if (load) begin
            sh     <= frame.bits;
            nbits  <= frame.nbits;
            cnt    <= '0;
            sclk   <= 1'b0;
            active <= 1'b1;
        end else if (active && tick) begin
            if (!sclk) begin
                sclk    <= 1'b1;
                rx_byte <= {rx_byte[DATA_W-2:0], miso};
            end else begin
                sclk <= 1'b0;
                sh   <= {sh[FRAME_W-2:0], 1'b0};
                cnt  <= cnt + 1'b1;
                if (last) begin
                    active <= 1'b0;
                end
            end
        end
    end

    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));                      // R6
    AST_BIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt < nbits));                                      // R5
    AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (rst)
        !active |-> !sclk);                                             // R6

endmodule

// File: rtl/radio_reg_spi_master.sv
module radio_reg_spi_master
    import rrm_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_long,
    input  logic       req_write,
    input  logic [9:0] req_addr,
    input  logic [7:0] req_wdata,
    output logic       ready,
    output logic       done,
    output logic [7:0] rdata,
    input  logic       irq_en_in,
    output logic       irq_en_out,
    output logic       spi_cs_n,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    rrm_state_e        state;
    logic              tick;
    logic              last;
    logic              load;
    logic              gap_half;
    logic [DATA_W-1:0] rx_byte;
    rrm_req_t          req;
    rrm_frame_t        frame;

    assign ready      = (state == ST_IDLE);
    assign load       = ready && req_valid;
    assign irq_en_out = irq_en_in && ready;

    always_comb begin
        req.long_space = req_long;
        req.write      = req_write;
        req.addr       = req_addr;
        req.wdata      = req_wdata;
        frame          = build_frame(req);
    end

    rrm_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (!ready),
        .tick (tick)
    );

    rrm_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .frame   (frame),
        .tick    (tick),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .last    (last),
        .rx_byte (rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            spi_cs_n <= 1'b1;
            done     <= 1'b0;
            rdata    <= '0;
            gap_half <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        spi_cs_n <= 1'b0;
                        state    <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (last) begin
                        spi_cs_n <= 1'b1;
                        gap_half <= 1'b0;
                        state    <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gap_half) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                            rdata <= rx_byte;
                        end else begin
                            gap_half <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> !irq_en_out);                                     // R8
    AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);                                        // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                // R7
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ready) |=> (!ready && !spi_cs_n));                // R7
    AST_DONE_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        done |-> (ready && spi_cs_n));                                  // R7

endmodule

// File: tb/test_radio_reg_spi_master.sv
module test_radio_reg_spi_master;

    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_long = 1'b0;
    logic       req_write = 1'b0;
    logic [9:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       ready, done;
    logic [7:0] rdata;
    logic       irq_en_in = 1'b1;
    logic       irq_en_out;
    logic       spi_cs_n, spi_sclk, spi_mosi;
    logic       spi_miso = 1'b0;

    always #10 clk = ~clk;

    radio_reg_spi_master #(.HALF_DIV(HALF)) i_radio_reg_spi_master (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_long(req_long),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .ready(ready), .done(done), .rdata(rdata), .irq_en_in(irq_en_in),
        .irq_en_out(irq_en_out), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] s_init(input int a);
        return 8'(a * 37) ^ 8'h5C;
    endfunction
    function automatic logic [7:0] l_init(input int a);
        return 8'(a) ^ {2'(a >> 8), 6'h2B};
    endfunction

    // ---------------- scoreboard queues ----------------
    typedef struct { logic [23:0] bytes; int nbits; string tag; } exp_frame_t;
    typedef struct { bit is_read; logic [7:0] value; string tag; } exp_rd_t;
    exp_frame_t q_frame[$];
    exp_rd_t    q_rd[$];

    logic [7:0] ref_s [64];
    logic [7:0] ref_l [1024];
    logic [7:0] sl_s  [64];
    logic [7:0] sl_l  [1024];

    // ---------------- slave model ----------------
    bit         started = 0;
    int         sl_nbits;
    logic [7:0] sl_cur;
    logic [7:0] sl_out;
    logic [7:0] sl_b [3];
    bit         sl_tx;
    int         frames_seen = 0;

    always @(negedge spi_cs_n) begin
        if (started) begin
            sl_nbits = 0; sl_tx = 0;
            sl_b[0] = 0; sl_b[1] = 0; sl_b[2] = 0;
        end
    end

    always @(posedge spi_sclk) begin
        if (started && !spi_cs_n) begin
            sl_cur = {sl_cur[6:0], spi_mosi};
            sl_nbits++;
            if (sl_nbits % 8 == 0 && sl_nbits <= 24) sl_b[sl_nbits/8 - 1] = sl_cur;
            if (sl_nbits == 8 && !sl_cur[7] && !sl_cur[0]) begin
                sl_out = sl_s[sl_cur[6:1]]; sl_tx = 1;
            end
            if (sl_nbits == 16 && sl_b[0][7] && !sl_cur[4]) begin
                sl_out = sl_l[{sl_b[0][6:0], sl_cur[7:5]}]; sl_tx = 1;
            end
        end
    end

    always @(negedge spi_sclk) begin
        if (started && sl_tx) begin
            spi_miso <= sl_out[7];
            sl_out = {sl_out[6:0], 1'b0};
        end
    end

    always @(posedge spi_cs_n) begin
        if (started) begin
            exp_frame_t e;
            frames_seen++;
            if (q_frame.size() == 0) begin
                chk(0, "R7 unexpected frame", {sl_b[0], sl_b[1], sl_b[2]}, 0);
            end else begin
                e = q_frame.pop_front();
                chk(sl_nbits == e.nbits, {e.tag, " bit count"}, sl_nbits, e.nbits);
                chk({sl_b[0], sl_b[1], sl_b[2]} == e.bytes, {e.tag, " frame bytes"},
                    {sl_b[0], sl_b[1], sl_b[2]}, e.bytes);
            end
            if (sl_nbits == 16 && !sl_b[0][7] && sl_b[0][0]) sl_s[sl_b[0][6:1]] = sl_b[1];
            if (sl_nbits == 24 && sl_b[0][7] && sl_b[1][4])
                sl_l[{sl_b[0][6:0], sl_b[1][7:5]}] = sl_b[2];
        end
    end

    // ---------------- protocol monitors ----------------
    bit   viol_mosi = 0, viol_irq = 0, prev_sclk = 0, prev_mosi = 0, prev_cs = 1;
    int   hi_cnt = 0;
    bit   had_frame = 0;

    always @(negedge clk) begin
        if (started) begin
            if (spi_sclk && prev_sclk && spi_mosi != prev_mosi) viol_mosi = 1;
            if (!spi_cs_n && irq_en_out) viol_irq = 1;
            if (prev_cs && !spi_cs_n) begin
                if (had_frame)
                    chk(hi_cnt >= 2 * HALF, "R7 cs_n high gap", hi_cnt, 2 * HALF);
                chk(!spi_sclk, "R6 sclk low at cs_n fall", spi_sclk, 0);
                had_frame = 1;
            end
            hi_cnt = spi_cs_n ? hi_cnt + 1 : 0;
            prev_sclk = spi_sclk; prev_mosi = spi_mosi; prev_cs = spi_cs_n;
        end
    end

    // result monitor
    always @(negedge clk) begin
        if (started && done) begin
            exp_rd_t r;
            if (q_rd.size() == 0) begin
                chk(0, "R7 unexpected done", 1, 0);
            end else begin
                r = q_rd.pop_front();
                if (r.is_read) chk(rdata == r.value, {r.tag, " read data"}, rdata, r.value);
                chk(!viol_mosi, "R6 mosi changed while sclk high", viol_mosi, 0);
                chk(!viol_irq, "R8 irq_en_out high during transfer", viol_irq, 0);
                chk(irq_en_out == irq_en_in, "R8 irq restored at done", irq_en_out, irq_en_in);
            end
            viol_mosi = 0; viol_irq = 0;
        end
    end

    // ---------------- driver ----------------
    task automatic access(input bit lng, input bit wr, input logic [9:0] a,
                          input logic [7:0] d, input bit strobe_busy);
        exp_frame_t f;
        exp_rd_t    r;
        logic [7:0] pay;
        pay = wr ? d : 8'h00;
        if (lng) begin
            f.bytes = {1'b1, a[9:3], a[2:0], wr, 4'b0000, pay};
            f.nbits = 24;
            f.tag   = wr ? "R4 R5 long write" : "R3 R4 R5 long read";
            r.value = ref_l[a];
            if (wr) ref_l[a] = d;
        end else begin
            f.bytes = {1'b0, a[5:0], wr, pay, 8'h00};
            f.nbits = 16;
            f.tag   = wr ? "R1 short write" : "R2 short read";
            r.value = ref_s[a[5:0]];
            if (wr) ref_s[a[5:0]] = d;
        end
        r.is_read = !wr;
        r.tag     = f.tag;
        q_frame.push_back(f);
        q_rd.push_back(r);
        while (!ready) @(negedge clk);
        req_valid = 1; req_long = lng; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        if (strobe_busy) begin
            repeat (3) @(negedge clk);
            req_valid = 1; req_long = ~lng; req_write = 1; req_addr = ~a; req_wdata = 8'hEE;
            repeat (3) @(negedge clk);
            req_valid = 0;
        end
        while (!ready) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin ref_s[i] = s_init(i); sl_s[i] = s_init(i); end
        for (int i = 0; i < 1024; i++) begin ref_l[i] = l_init(i); sl_l[i] = l_init(i); end
        repeat (4) @(negedge clk);
        rst = 0;
        started = 1;
        @(negedge clk);
        // R9 reset state
        chk(spi_cs_n == 1'b1, "R9 cs_n after reset", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R9 sclk after reset", spi_sclk, 0);
        chk(ready == 1'b1, "R9 ready after reset", ready, 1);
        chk(done == 1'b0, "R9 done after reset", done, 0);
        chk(irq_en_out == 1'b1, "R8 irq passes when idle", irq_en_out, 1);

        access(0, 1, 10'h015, 8'hA5, 0);
        access(0, 0, 10'h015, 8'h00, 0);
        access(0, 0, 10'h03F, 8'h00, 0);
        access(0, 0, 10'h000, 8'h00, 0);
        access(0, 1, 10'h02A, 8'h01, 0);
        access(0, 0, 10'h02A, 8'h00, 0);
        access(1, 1, 10'h3FF, 8'h5A, 0);
        access(1, 0, 10'h3FF, 8'h00, 0);
        access(1, 0, 10'h000, 8'h00, 0);
        access(1, 0, 10'h2A7, 8'h00, 0);
        access(1, 1, 10'h001, 8'hFF, 1);   // R7 strobe while busy is ignored
        access(1, 0, 10'h001, 8'h00, 0);
        access(1, 0, 10'h158, 8'h00, 0);
        access(1, 1, 10'h210, 8'h3C, 0);
        irq_en_in = 0;
        access(0, 0, 10'h011, 8'h00, 0);
        chk(irq_en_out == 1'b0, "R8 irq stays off when host disables", irq_en_out, 0);
        irq_en_in = 1;
        @(negedge clk);
        access(1, 0, 10'h210, 8'h00, 0);
        access(0, 0, 10'h02A, 8'h00, 1);   // R7 again on short space

        repeat (20) @(negedge clk);
        chk(q_frame.size() == 0, "R7 all frames observed", q_frame.size(), 0);
        chk(q_rd.size() == 0, "R7 all done pulses observed", q_rd.size(), 0);
        chk(frames_seen == 17, "R7 frame count", frames_seen, 17);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule